// File: doc/BRIEF.md
# Phase-Accumulator Multi-Waveform Voice Oscillator

This block is one tone oscillator of a three-voice synthesizer. A 24-bit phase register advances by a 16-bit frequency word on every clock. The output tone frequency is therefore `freq * Fclk / 2^24`. From the phase the block derives four shapes: a rising ramp, a folded triangle, a pulse of programmable width, and a pseudo-random noise word. Any subset of these can be selected. When more than one is selected, they are merged by a bitwise AND. The result is a 12-bit sample. The top eight bits of the sample are also brought out on a separate read-back port.

Three instances are meant to be wired in a ring. Each voice exports its phase MSB and a one-cycle pulse that marks a rising edge of that MSB. Each voice takes the same two signals from the previous voice in the ring. They serve two purposes. One is hard sync, which clears this voice's phase when the neighbour wraps. The other is ring modulation, which inverts the triangle fold using the neighbour's MSB. A test bit clears and freezes the phase, reseeds the noise generator and forces the pulse shape high.

All inputs are plain levels that the oscillator samples continuously. The block has no transfer handshake, so there is no back-pressure: every clock produces one new sample, and a consumer that wants samples at a lower rate simply takes the ones it needs.

Control byte layout (`mode`): bit 0 ramp, bit 1 triangle, bit 2 pulse, bit 3 noise, bit 4 test, bit 5 ring, bit 6 sync, bit 7 gate.

Top module: `osc_voice`

## Requirements
- R1: On reset the 24-bit phase is 0. On each clock edge out of reset, with test and sync inactive, the phase gains `freq` modulo 2^24. `phase_msb` is phase bit 23.
- R2: With only bit 0 of `mode` set, `wave` equals phase bits 23..12.
- R3: With only bit 1 set, a fold bit is formed as phase bit 23 XOR (`mode` bit 5 AND `nbr_msb`). `wave` is phase bits 22..11 when the fold bit is 0, and their bitwise inverse when it is 1.
- R4: With only bit 2 set and test clear, `wave` is all ones while phase bits 23..12 are below `pw`, and zero otherwise. A `pw` of 0 therefore gives a constant zero.
- R5: With only bit 3 set, `wave` bits 11..4 are bits 20,18,14,11,9,5,2,0 (MSB first) of a 23-bit shift register, and `wave` bits 3..0 are zero. The register resets to all ones. It shifts left with bit 22 XOR bit 17 entering bit 0, one clock after phase bit 19 goes from 0 to 1.
- R6: With several of bits 0..3 set, `wave` is the bitwise AND of the selected shapes. With none set, `wave` is 0.
- R7: While `mode` bit 4 (test) is 1, every clock edge loads the phase with 0 and the noise register with all ones, and the pulse shape is all ones.
- R8: While `mode` bit 6 is 1 and test is 0, a clock edge at which `nbr_sync` is 1 loads the phase with 0 instead of adding `freq`.
- R9: `sync_out` is 1 exactly in the cycle after a clock edge on which `phase_msb` went from 0 to 1.
- R10: `mode` bit 7 (gate) has no effect on any output.
- R11: `wave_rd` always equals `wave` bits 11..4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one phase step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq | input | 16 | Phase increment per clock |
| pw | input | 12 | Pulse width threshold |
| mode | input | 8 | Shape select, test, ring, sync and gate bits |
| nbr_msb | input | 1 | Phase MSB of the modulating neighbour |
| nbr_sync | input | 1 | Wrap pulse of the modulating neighbour |
| wave | output | 12 | Combined waveform sample |
| phase_msb | output | 1 | Phase bit 23, for the next voice |
| sync_out | output | 1 | One-cycle pulse on a rising phase MSB |
| wave_rd | output | 8 | Top eight bits of `wave` |

## Verification
Phase, noise state and `sync_out` are registered. They take on their new values at the clock edge that follows the stimulus. `sync_out` appears one edge after the MSB rises. The noise register shifts one further edge after phase bit 19 rises. Shape selection, `pw`, ring and `nbr_msb` reach `wave` in the same cycle, with no register between them. The bench changes inputs on the falling edge and updates its reference phase and noise state on each rising edge. It compares every output on the next falling edge, so each check sees the edge its result is due from.

// File: rtl/osc_pkg.sv
package osc_pkg;
  // control byte bit positions
  localparam int CB_SAW  = 0;
  localparam int CB_TRI  = 1;
  localparam int CB_PUL  = 2;
  localparam int CB_NOI  = 3;
  localparam int CB_TEST = 4;
  localparam int CB_RING = 5;
  localparam int CB_SYNC = 6;
  localparam int CB_GATE = 7;
  localparam int NSHAPES = 4;

  localparam int LFSR_W = 23;
  localparam int TAP_W  = 8;

  function automatic logic [TAP_W-1:0] noise_taps(input logic [LFSR_W-1:0] s);
    return {s[20], s[18], s[14], s[11], s[9], s[5], s[2], s[0]};
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[22] ^ s[17]};
  endfunction
endpackage

// File: rtl/osc_phase.sv
module osc_phase #(
  parameter int ACC_W  = 24,
  parameter int FREQ_W = 16,
  parameter int TICK_B = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] freq,
  input  logic              test,
  input  logic              sync_en,
  input  logic              nbr_sync,
  output logic [ACC_W-1:0]  acc,
  output logic              sync_out,
  output logic              noise_tick
);
  localparam int PAD_W = ACC_W - FREQ_W;

  logic msb_q;
  logic tick_q;
  logic [ACC_W-1:0] acc_nxt;

  always_comb begin
    if (test || (sync_en && nbr_sync)) acc_nxt = '0;
    else                               acc_nxt = acc + {{PAD_W{1'b0}}, freq};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      msb_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      acc    <= acc_nxt;
      msb_q  <= acc[ACC_W-1];
      tick_q <= acc[TICK_B];
    end
  end

  assign sync_out   = acc[ACC_W-1] & ~msb_q;
  assign noise_tick = acc[TICK_B] & ~tick_q;
endmodule

// File: rtl/osc_noise.sv
module osc_noise
  import osc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test,
  input  logic             tick,
  output logic [TAP_W-1:0] taps
);
  logic [LFSR_W-1:0] state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state <= '1;
    else if (test)  state <= '1;
    else if (tick)  state <= lfsr_step(state);
  end

  assign taps = noise_taps(state);
endmodule

// File: rtl/osc_shaper.sv
module osc_shaper
  import osc_pkg::*;
#(
  parameter int OUT_W = 12,
  parameter int PW_W  = 12
) (
  input  logic [OUT_W:0]      top,    // upper OUT_W+1 phase bits
  input  logic [PW_W-1:0]     pw,
  input  logic [NSHAPES-1:0]  sel,
  input  logic                test,
  input  logic                ring,
  input  logic                nbr_msb,
  input  logic [TAP_W-1:0]    taps,
  output logic [OUT_W-1:0]    wave
);
  logic [OUT_W-1:0] shape [NSHAPES];
  logic [OUT_W-1:0] part  [NSHAPES+1];
  logic fold;
  logic pul_hi;

  assign fold   = top[OUT_W] ^ (ring & nbr_msb);
  assign pul_hi = test || (top[OUT_W -: PW_W] < pw);

  assign shape[CB_SAW] = top[OUT_W -: OUT_W];
  assign shape[CB_TRI] = fold ? ~top[OUT_W-1:0] : top[OUT_W-1:0];
  assign shape[CB_PUL] = {OUT_W{pul_hi}};
  assign shape[CB_NOI] = {taps, {(OUT_W-TAP_W){1'b0}}};

  assign part[0] = '1;
  for (genvar g = 0; g < NSHAPES; g++) begin : g_and
    assign part[g+1] = sel[g] ? (part[g] & shape[g]) : part[g];
  end

  assign wave = (|sel) ? part[NSHAPES] : '0;
endmodule

// File: rtl/osc_voice.sv
module osc_voice
  import osc_pkg::*;
#(
  parameter int ACC_W  = 24,
  parameter int FREQ_W = 16,
  parameter int PW_W   = 12,
  parameter int OUT_W  = 12,
  parameter int TICK_B = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] freq,
  input  logic [PW_W-1:0]   pw,
  input  logic [7:0]        mode,
  input  logic              nbr_msb,
  input  logic              nbr_sync,
  output logic [OUT_W-1:0]  wave,
  output logic              phase_msb,
  output logic              sync_out,
  output logic [TAP_W-1:0]  wave_rd
);
  logic [ACC_W-1:0] acc;
  logic             tick;
  logic [TAP_W-1:0] taps;
  logic             gate_unused;
  logic [ACC_W-OUT_W-2:0] low_unused;

  assign gate_unused = mode[CB_GATE];
  assign low_unused  = acc[ACC_W-OUT_W-2:0];

  osc_phase #(.ACC_W(ACC_W), .FREQ_W(FREQ_W), .TICK_B(TICK_B)) u_phase (
    .clk(clk), .rst_n(rst_n), .freq(freq), .test(mode[CB_TEST]),
    .sync_en(mode[CB_SYNC]), .nbr_sync(nbr_sync), .acc(acc),
    .sync_out(sync_out), .noise_tick(tick)
  );

  osc_noise u_noise (
    .clk(clk), .rst_n(rst_n), .test(mode[CB_TEST]), .tick(tick), .taps(taps)
  );

  osc_shaper #(.OUT_W(OUT_W), .PW_W(PW_W)) u_shape (
    .top(acc[ACC_W-1 -: OUT_W+1]), .pw(pw), .sel(mode[NSHAPES-1:0]),
    .test(mode[CB_TEST]), .ring(mode[CB_RING]), .nbr_msb(nbr_msb),
    .taps(taps), .wave(wave)
  );

  assign phase_msb = acc[ACC_W-1];
  assign wave_rd   = wave[OUT_W-1 -: TAP_W];
endmodule

// File: rtl/osc_voice_chk.sv
module osc_voice_chk #(
  parameter int OUT_W = 12,
  parameter int PW_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PW_W-1:0]  pw,
  input logic [7:0]       mode,
  input logic             nbr_sync,
  input logic [OUT_W-1:0] wave,
  input logic             phase_msb,
  input logic             sync_out
);
  // R7
  test_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode[4] |=> !phase_msb);
  // R8
  hard_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[6] && nbr_sync) |=> !phase_msb);
  // R9
  sync_pulse_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> phase_msb);
  // R9
  sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |=> !sync_out);
  // R6
  no_shape_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:0] == 4'h0) |-> (wave == '0));
  // R4
  pulse_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:0] == 4'h4 && !mode[4] && pw == '0) |-> (wave == '0));
endmodule

bind osc_voice osc_voice_chk #(.OUT_W(OUT_W), .PW_W(PW_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .pw(pw), .mode(mode), .nbr_sync(nbr_sync),
  .wave(wave), .phase_msb(phase_msb), .sync_out(sync_out)
);

// File: tb/test_osc_voice.sv
module test_osc_voice;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] freq = '0;
  logic [11:0] pw = '0;
  logic [7:0]  mode = '0;
  logic        nbr_msb = 1'b0;
  logic        nbr_sync = 1'b0;
  logic [11:0] wave;
  logic        phase_msb;
  logic        sync_out;
  logic [7:0]  wave_rd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  osc_voice i_osc_voice (
    .clk(clk), .rst_n(rst_n), .freq(freq), .pw(pw), .mode(mode),
    .nbr_msb(nbr_msb), .nbr_sync(nbr_sync), .wave(wave),
    .phase_msb(phase_msb), .sync_out(sync_out), .wave_rd(wave_rd)
  );

  // reference state
  logic [23:0] m_acc = '0;
  logic        m_msbq = 1'b0;
  logic        m_b19q = 1'b0;
  logic [22:0] m_lfsr = '1;

  always @(posedge clk) begin
    if (rst_n) begin
      if (mode[4])                  m_lfsr <= '1;
      else if (m_acc[19] && !m_b19q) m_lfsr <= {m_lfsr[21:0], m_lfsr[22] ^ m_lfsr[17]};
      m_b19q <= m_acc[19];
      m_msbq <= m_acc[23];
      if (mode[4] || (mode[6] && nbr_sync)) m_acc <= '0;
      else                                  m_acc <= m_acc + {8'h0, freq};
    end
  end

  function automatic logic [11:0] exp_wave();
    logic [11:0] r;
    logic fold;
    r = '1;
    fold = m_acc[23] ^ (mode[5] & nbr_msb);
    if (mode[0]) r &= m_acc[23:12];
    if (mode[1]) r &= fold ? ~m_acc[22:11] : m_acc[22:11];
    if (mode[2]) r &= (mode[4] || m_acc[23:12] < pw) ? 12'hFFF : 12'h000;
    if (mode[3]) r &= {m_lfsr[20], m_lfsr[18], m_lfsr[14], m_lfsr[11],
                       m_lfsr[9], m_lfsr[5], m_lfsr[2], m_lfsr[0], 4'h0};
    if (mode[3:0] == 4'h0) r = '0;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    logic [11:0] w;
    w = exp_wave();
    chk(tag, {20'h0, wave}, {20'h0, w});
    chk("R1", {31'h0, phase_msb}, {31'h0, m_acc[23]});
    chk("R9", {31'h0, sync_out}, {31'h0, m_acc[23] & ~m_msbq});
    chk("R11", {24'h0, wave_rd}, {24'h0, w[11:4]});
  endtask

  task automatic run(int n, string tag, bit rnd_nbr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all(tag);
      if (rnd_nbr) begin
        nbr_msb  = 1'($urandom);
        nbr_sync = ($urandom % 8) == 0;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1: reset state, nothing selected
    chk("R1", {31'h0, phase_msb}, 32'h0);
    chk("R6", {20'h0, wave}, 32'h0);
    chk("R9", {31'h0, sync_out}, 32'h0);
    rst_n = 1'b1;
    // R1 R2: ramp
    freq = 16'h1234; mode = 8'h01;
    run(400, "R2", 0);
    // R3: triangle, then ring with a toggling neighbour
    freq = 16'hFFFF; mode = 8'h02;
    run(600, "R3", 0);
    mode = 8'h22;
    run(600, "R3", 1);
    // R4: pulse widths
    mode = 8'h04; pw = 12'h000;
    run(300, "R4", 0);
    pw = 12'h800;
    run(300, "R4", 0);
    pw = 12'hFFF;
    run(300, "R4", 0);
    // R5: noise
    mode = 8'h08; pw = 12'h123;
    run(2000, "R5", 0);
    // R6: combinations
    mode = 8'h03; run(300, "R6", 0);
    mode = 8'h05; pw = 12'h600; run(300, "R6", 0);
    mode = 8'h09; run(300, "R6", 0);
    mode = 8'h00; run(50, "R6", 0);
    // R7: test lock, then release
    mode = 8'h15; pw = 12'h000;
    run(40, "R7", 0);
    mode = 8'h18; run(20, "R7", 0);
    mode = 8'h08; run(300, "R7", 0);
    // R8: hard sync with random neighbour wraps
    mode = 8'h41; freq = 16'h0800;
    run(1500, "R8", 1);
    // R10: gate toggling
    mode = 8'h81; freq = 16'h0777;
    for (int k = 0; k < 20; k++) begin
      mode[7] = ~mode[7];
      run(25, "R10", 0);
    end
    // random blocks
    for (int b = 0; b < 60; b++) begin
      freq = 16'($urandom);
      pw   = 12'($urandom);
      mode = 8'($urandom);
      if (($urandom % 4) != 0) mode[4] = 1'b0;
      run(200, "R6", 1);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule